// File: doc/BRIEF.md
# Register-Triggered Serial Control Shifter

This block owns two write-only control bytes on a simple host register bus and forwards them to an external line-interface device over a three-wire serial link. A host write to either byte is enough to launch a transfer. No start command exists. The sequencer sends a 16-bit frame made of both bytes, least significant bit first. It drives an active-low select, a serial clock and a data line.

The host bus runs on its own clock. All serial timing comes from the line receive clock. A write request crosses into the receive domain as a toggle, while the register contents are held still. A second toggle comes back to the host domain to close the transfer.

A busy flag covers the whole transfer. Software is expected to space its writes (on the order of 20 µs). A write that still lands while busy is dropped, and a sticky overrun flag records it.

Top module: `serial_ctl_shifter`

## Requirements
- R1: A host write (bus_sel=1, bus_wr=1) to address 0x18 loads control byte 1, which forms frame bits 0..7. A write to 0x19 loads control byte 2, which forms frame bits 8..15. A write to any other address changes no register and starts no transfer.
- R2: Every accepted write to 0x18 or 0x19 starts exactly one serial transfer on its own. The frame sent is {byte2, byte1} with the byte just written already updated.
- R3: Frame bits leave least significant first: bit 0 of byte 1 first, bit 7 of byte 2 last.
- R4: ctl_sclk idles low and is high for exactly one receive-clock period per bit, with one low period between bits. ctl_sdo changes only while ctl_sclk is low and holds its value across each rising edge. ctl_sclk is never high while ctl_cs_n is high.
- R5: ctl_cs_n falls one receive-clock period before the first ctl_sclk rising edge. It returns high one period after the last falling edge. Exactly 16 rising edges occur while it is low.
- R6: A host read of any address returns bus_rdata = 0.
- R7: busy is high from the host cycle after an accepted write until the transfer has finished. When busy returns low, ctl_cs_n is already high.
- R8: A write to 0x18 or 0x19 while busy is high changes no register and starts no transfer. It sets overrun, which stays high until reset.
- R9: After reset, both control bytes are 0, ctl_cs_n=1, ctl_sclk=0, ctl_sdo=0, busy=0 and overrun=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_host | input | 1 | Host bus clock |
| clk_rx | input | 1 | Line receive clock, times all shifting |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain synchronously |
| bus_sel | input | 1 | Host access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Host register address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, always zero |
| busy | output | 1 | Transfer in progress (host domain) |
| overrun | output | 1 | Sticky: a write arrived while busy |
| ctl_cs_n | output | 1 | Active-low select to the line-interface device |
| ctl_sclk | output | 1 | Serial clock, half the receive-clock rate |
| ctl_sdo | output | 1 | Serial data, LSB first |

## Verification
The hardest case to reach from the ports is a write that lands while the transfer is still running. Showing that it changed nothing is harder still, because the registers cannot be read back. The stimulus issues a second write one host cycle after an accepted one, while busy is high. It then waits for idle and writes only the other byte. The next frame on the serial pins must still carry the old value of the byte the dropped write aimed at. A write to a neighbouring address is proved harmless in the same way, through the contents of the following frame.

// File: rtl/ser_ctl_pkg.sv
package ser_ctl_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_LEAD = 3'd1,
    SQ_HI   = 3'd2,
    SQ_LO   = 3'd3,
    SQ_TAIL = 3'd4
  } sq_state_e;
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = d;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ctl_host_regs.sv
module ctl_host_regs #(
  parameter int                ADDR_W      = 8,
  parameter int                DATA_W      = 8,
  parameter int                NUM_BYTES   = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 8'h18,
  parameter int                SYNC_STAGES = 2,
  localparam int               FRAME_W     = DATA_W * NUM_BYTES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               ack_tgl_rx,
  output logic [FRAME_W-1:0] frame_data,
  output logic               req_tgl,
  output logic               busy,
  output logic               overrun
);
  logic [NUM_BYTES-1:0] hit;
  logic                 any_hit;
  logic                 accept;
  logic                 ack_h;
  logic                 req_tgl_d;
  logic                 overrun_d;

  ser_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(ack_tgl_rx), .q(ack_h)
  );

  assign busy    = req_tgl ^ ack_h;
  assign any_hit = |hit;
  assign accept  = any_hit && !busy;

  generate
    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
      localparam logic [ADDR_W-1:0] SLOT_ADDR = BASE_ADDR + ADDR_W'(i);
      logic [DATA_W-1:0] byte_q;
      logic [DATA_W-1:0] byte_d;
      logic              byte_en;

      assign hit[i]  = bus_sel && bus_wr && (bus_addr == SLOT_ADDR);
      assign byte_en = hit[i] && !busy;

      always_comb begin
        byte_d = byte_q;
        if (byte_en) byte_d = bus_wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) byte_q <= '0;
        else        byte_q <= byte_d;
      end

      assign frame_data[i*DATA_W +: DATA_W] = byte_q;
    end
  endgenerate

  always_comb begin
    req_tgl_d = req_tgl;
    overrun_d = overrun;
    if (accept)          req_tgl_d = ~req_tgl;
    if (any_hit && busy) overrun_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_tgl <= 1'b0;
      overrun <= 1'b0;
    end else begin
      req_tgl <= req_tgl_d;
      overrun <= overrun_d;
    end
  end

  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  // R8
  ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_hit && busy) |=> ($stable(frame_data) && overrun));
endmodule

// File: rtl/ctl_shift_seq.sv
module ctl_shift_seq
  import ser_ctl_pkg::*;
#(
  parameter int  FRAME_W     = 16,
  parameter int  SYNC_STAGES = 2,
  localparam int CNT_W       = (FRAME_W > 2) ? $clog2(FRAME_W) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_tgl_h,
  input  logic [FRAME_W-1:0] frame_data_h,
  output logic               ack_tgl,
  output logic               sel_n,
  output logic               sclk,
  output logic               sdat
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  sq_state_e          state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic               sel_n_d, sclk_d, sdat_d, ack_d;
  logic               req_s, req_seen_q, start;

  ser_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d(req_tgl_h), .q(req_s)
  );

  assign start = req_s ^ req_seen_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    sel_n_d = sel_n;
    sclk_d  = sclk;
    sdat_d  = sdat;
    ack_d   = ack_tgl;
    unique case (state_q)
      SQ_IDLE: begin
        if (start) begin
          sh_d    = frame_data_h;
          sdat_d  = frame_data_h[0];
          sel_n_d = 1'b0;
          cnt_d   = '0;
          state_d = SQ_LEAD;
        end
      end
      SQ_LEAD: begin
        sclk_d  = 1'b1;
        state_d = SQ_HI;
      end
      SQ_HI: begin
        sclk_d = 1'b0;
        if (cnt_q == LAST_BIT) begin
          state_d = SQ_TAIL;
        end else begin
          cnt_d   = cnt_q + 1'b1;
          sh_d    = sh_q >> 1;
          sdat_d  = sh_q[1];
          state_d = SQ_LO;
        end
      end
      SQ_LO: begin
        sclk_d  = 1'b1;
        state_d = SQ_HI;
      end
      SQ_TAIL: begin
        sel_n_d = 1'b1;
        sdat_d  = 1'b0;
        ack_d   = req_seen_q;
        state_d = SQ_IDLE;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SQ_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      sel_n      <= 1'b1;
      sclk       <= 1'b0;
      sdat       <= 1'b0;
      ack_tgl    <= 1'b0;
      req_seen_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      sh_q       <= sh_d;
      sel_n      <= sel_n_d;
      sclk       <= sclk_d;
      sdat       <= sdat_d;
      ack_tgl    <= ack_d;
      req_seen_q <= req_s;
    end
  end

  // R4
  sclk_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !sel_n);
  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdat));
  // R4
  half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |=> !sclk);
  // R5
  lead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_n) |-> (!sclk ##1 sclk));
  // R5
  tail_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_n) |-> (!$past(sclk) && $past(sclk, 2)));
endmodule

// File: rtl/serial_ctl_shifter.sv
module serial_ctl_shifter #(
  parameter int          ADDR_W      = 8,
  parameter int          DATA_W      = 8,
  parameter int          NUM_BYTES   = 2,
  parameter logic [7:0]  BASE_ADDR   = 8'h18,
  parameter int          SYNC_STAGES = 2,
  localparam int         FRAME_W     = DATA_W * NUM_BYTES
) (
  input  logic              clk_host,
  input  logic              clk_rx,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              busy,
  output logic              overrun,
  output logic              ctl_cs_n,
  output logic              ctl_sclk,
  output logic              ctl_sdo
);
  logic               rst_host_n;
  logic               rst_rx_n;
  logic [FRAME_W-1:0] frame_data;
  logic               req_tgl;
  logic               ack_tgl;

  ser_sync #(.STAGES(2)) u_rst_host (
    .clk(clk_host), .rst_n(rst_n), .d(1'b1), .q(rst_host_n)
  );
  ser_sync #(.STAGES(2)) u_rst_rx (
    .clk(clk_rx), .rst_n(rst_n), .d(1'b1), .q(rst_rx_n)
  );

  assign bus_rdata = '0;

  ctl_host_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BYTES(NUM_BYTES),
    .BASE_ADDR(ADDR_W'(BASE_ADDR)), .SYNC_STAGES(SYNC_STAGES)
  ) u_regs (
    .clk(clk_host), .rst_n(rst_host_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .ack_tgl_rx(ack_tgl), .frame_data(frame_data), .req_tgl(req_tgl),
    .busy(busy), .overrun(overrun)
  );

  ctl_shift_seq #(
    .FRAME_W(FRAME_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_seq (
    .clk(clk_rx), .rst_n(rst_rx_n),
    .req_tgl_h(req_tgl), .frame_data_h(frame_data), .ack_tgl(ack_tgl),
    .sel_n(ctl_cs_n), .sclk(ctl_sclk), .sdat(ctl_sdo)
  );

  // R6
  rdata_zero_chk: assert property (@(posedge clk_host) disable iff (!rst_host_n)
    (bus_sel && !bus_wr) |-> (bus_rdata == '0));
endmodule

// File: tb/test_serial_ctl_shifter.sv
`timescale 1ns/1ps
module test_serial_ctl_shifter;
  logic       clk_host = 1'b0;
  logic       clk_rx   = 1'b0;
  logic       rst_n    = 1'b0;
  logic       bus_sel  = 1'b0;
  logic       bus_wr   = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       busy, overrun, ctl_cs_n, ctl_sclk, ctl_sdo;

  always #2.5 clk_host = ~clk_host;
  always #7   clk_rx   = ~clk_rx;

  serial_ctl_shifter i_serial_ctl_shifter (
    .clk_host(clk_host), .clk_rx(clk_rx), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .busy(busy), .overrun(overrun),
    .ctl_cs_n(ctl_cs_n), .ctl_sclk(ctl_sclk), .ctl_sdo(ctl_sdo)
  );

  int          n_checks = 0;
  int          n_fails  = 0;
  bit          finished = 1'b0;
  logic [15:0] exp_q[$];
  logic [7:0]  m_b1 = 8'h00;
  logic [7:0]  m_b2 = 8'h00;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
  endtask

  // driver: performs the bus write and pushes the expected frame
  task automatic host_write(input logic [7:0] a, input logic [7:0] d, input bit accepted);
    @(negedge clk_host);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk_host);
    bus_sel = 1'b0; bus_wr = 1'b0;
    if (accepted && (a == 8'h18 || a == 8'h19)) begin
      if (a == 8'h18) m_b1 = d; else m_b2 = d;
      exp_q.push_back({m_b2, m_b1});
    end
  endtask

  task automatic host_read(input logic [7:0] a);
    @(negedge clk_host);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    chk(bus_rdata == 8'h00, "R6", "read data", bus_rdata, 0);
    @(negedge clk_host);
    bus_sel = 1'b0;
  endtask

  task automatic wait_idle();
    int k;
    k = 0;
    while (busy && k < 5000) begin
      @(negedge clk_host);
      k++;
    end
    chk(!busy, "R7", "busy clears", busy, 0);
    chk(ctl_cs_n, "R7", "select high when busy clears", ctl_cs_n, 1);
    repeat (4) @(negedge clk_host);
  endtask

  // monitor: rebuilds frames from the serial pins and compares with the queue
  logic        prev_cs = 1'b1, prev_sclk = 1'b0, prev2_sclk = 1'b0, prev_sdo = 1'b0;
  int          nrise = 0, since_fall = 0;
  logic [15:0] got = '0;
  logic [15:0] want;

  always @(negedge clk_rx) begin
    if (rst_n) begin
      if (ctl_cs_n && ctl_sclk) chk(0, "R4", "clock while deselected", 1, 0);
      if (prev_cs && !ctl_cs_n) begin
        nrise = 0; since_fall = 0; got = '0;
        chk(!ctl_sclk, "R5", "sclk low at select fall", ctl_sclk, 0);
      end else if (!ctl_cs_n) begin
        since_fall++;
      end
      if (!ctl_cs_n && ctl_sclk && !prev_sclk) begin
        if (nrise == 0) chk(since_fall == 1, "R5", "lead gap", since_fall, 1);
        chk(ctl_sdo == prev_sdo, "R4", "data stable at rising edge", ctl_sdo, prev_sdo);
        if (nrise < 16) got[nrise] = ctl_sdo;
        nrise++;
      end
      if (!ctl_cs_n && ctl_sclk && prev_sclk) chk(0, "R4", "sclk high over one period", 2, 1);
      if (!ctl_cs_n && !ctl_sclk && !prev_sclk && !prev_cs)
        chk(0, "R4", "sclk low over one period", 2, 1);
      if (!prev_cs && ctl_cs_n) begin
        chk(nrise == 16, "R5", "rising edges per frame", nrise, 16);
        chk(!prev_sclk && prev2_sclk, "R5", "tail gap", {prev2_sclk, prev_sclk}, 2'b10);
        if (exp_q.size() > 0) begin
          want = exp_q.pop_front();
          chk(got == want, "R3", "frame bits LSB first", got, want);
        end else begin
          chk(0, "R2", "frame with no write", got, 0);
        end
      end
      prev2_sclk = prev_sclk;
      prev_sclk  = ctl_sclk;
      prev_cs    = ctl_cs_n;
      prev_sdo   = ctl_sdo;
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk_host);
    rst_n = 1'b1;
    repeat (10) @(negedge clk_host);

    // R9 reset state
    chk(ctl_cs_n == 1'b1, "R9", "cs_n after reset", ctl_cs_n, 1);
    chk(ctl_sclk == 1'b0, "R9", "sclk after reset", ctl_sclk, 0);
    chk(ctl_sdo == 1'b0, "R9", "sdo after reset", ctl_sdo, 0);
    chk(busy == 1'b0, "R9", "busy after reset", busy, 0);
    chk(overrun == 1'b0, "R9", "overrun after reset", overrun, 0);
    host_read(8'h18);
    host_read(8'h19);

    // R9/R1: byte 2 still zero after reset; R2 auto start
    host_write(8'h18, 8'hA5, 1);
    chk(busy, "R7", "busy after accepted write", busy, 1);
    wait_idle();
    host_write(8'h19, 8'h3C, 1);
    chk(busy, "R2", "write to 0x19 starts transfer", busy, 1);
    wait_idle();
    host_read(8'h19);

    // R1: other address ignored
    host_write(8'h1A, 8'h77, 0);
    repeat (3) @(negedge clk_host);
    chk(!busy, "R1", "no transfer for 0x1A", busy, 0);
    host_write(8'h17, 8'h66, 0);
    repeat (3) @(negedge clk_host);
    chk(!busy, "R1", "no transfer for 0x17", busy, 0);
    host_write(8'h18, 8'h0F, 1);
    wait_idle();

    // R8: write while busy dropped, overrun sticky
    host_write(8'h18, 8'h81, 1);
    host_write(8'h19, 8'hFF, 0);
    chk(overrun, "R8", "overrun on write while busy", overrun, 1);
    chk(busy, "R8", "still busy", busy, 1);
    wait_idle();
    chk(overrun, "R8", "overrun sticky", overrun, 1);
    host_write(8'h18, 8'hC3, 1);
    wait_idle();
    chk(overrun, "R8", "overrun still set", overrun, 1);

    // further patterns
    host_write(8'h19, 8'h80, 1); wait_idle();
    host_write(8'h18, 8'h01, 1); wait_idle();
    host_write(8'h19, 8'h5A, 1); wait_idle();
    host_write(8'h18, 8'hFF, 1); wait_idle();
    host_read(8'h18);

    repeat (20) @(negedge clk_host);
    chk(exp_q.size() == 0, "R2", "all frames seen", exp_q.size(), 0);
    finished = 1'b1;
    report();
    $finish;
  end
endmodule